// File: doc/BRIEF.md
# Sectioned Clock Register Access Controller

This block is the byte-level engine behind a serial-bus slave front end for a clock and control register space. The front end gives it strobes for operation start, operation stop, address load, byte write and byte read. The block keeps the address pointer and steps it through the register space. A burst never leaves the section where it began: when it passes the last byte, it wraps back to the first byte of that section.

Written bytes are held in a staging buffer and take effect only when the operation ends with a stop. They take effect only if a write-enable latch, armed in two steps through the status register, permits it. The status register is a one-byte section that is always writable. The running clock is copied when each operation starts, so a burst read returns bytes from a single instant. Clock writes leave the block as a masked load pulse toward the timekeeping counter. The alarm and control bytes are held in an internal register array.

Top module: `clkreg_access`

## Requirements
- R1: After reset the pointer is at address 0x00, the alarm and control bytes read 0x00, the status register reads 0x00, and `rd_valid` and `rtc_set` are low.
- R2: A burst read or write that passes the last byte of its section continues at the first byte of the same section. For example, control 0x13 is followed by 0x10, and clock 0x37 is followed by 0x30.
- R3: The decoded sections are alarm A at 0x00–0x07, alarm B at 0x08–0x0F, control at 0x10–0x13, clock at 0x30–0x37 and status at 0x3F. A byte strobe while the pointer is at any other address is ignored: no `rd_valid`, nothing staged and nothing committed.
- R4: The status section takes one byte per operation. Any further byte strobe in that operation is ignored and ends the operation: no `rd_valid` and no effect. The first byte still counts.
- R5: Alarm, control and clock bytes are staged. They are committed only at a stop, and only if the register write-enable bit is set. Otherwise the stored bytes are unchanged and `rtc_set` stays low.
- R6: The status register can be written at any time. Bit 1 is the write-enable bit, bit 2 is the register write-enable bit, and all other bits read 0.
- R7: A status write that sets bit 1 sets write-enable. Register write-enable becomes 1 only if write-enable was already 1 before that write and the byte has both bits 1 and 2 set. A status write with bit 1 clear clears both bits.
- R8: At each start the eight clock bytes on `rtc_now` are captured. Byte i is `rtc_now[8i+7:8i]` at address 0x30+i. Clock reads in that operation return the captured bytes, not the live input.
- R9: The pointer persists across operations. A read or write with no address load continues at the last accessed address plus one, wrapped within its section.
- R10: A stop that arrives before any byte is completed commits nothing. A new start discards bytes staged by an operation that had no stop.
- R11: A committed clock write pulses `rtc_set` for exactly one cycle after the stop cycle. `rtc_set_mask` bit i marks each written byte i, and the data is at `rtc_set_data[8i+7:8i]`.
- R12: Read data appears on `rd_data` with `rd_valid` high in the cycle after the accepted `rd_byte` strobe. `rd_valid` is high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Start of an operation (also a repeated start) |
| bus_stop | input | 1 | End of an operation; commits staged bytes |
| addr_load | input | 1 | Load the pointer from `addr_in` |
| addr_in | input | 8 | Register address |
| wr_byte | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to write |
| rd_byte | input | 1 | Read strobe for one byte |
| rd_data | output | 8 | Byte read |
| rd_valid | output | 1 | `rd_data` valid this cycle |
| rtc_now | input | 64 | Live clock bytes from the timekeeping counter |
| rtc_set | output | 1 | One-cycle load pulse toward the counter |
| rtc_set_data | output | 64 | Clock bytes to load |
| rtc_set_mask | output | 8 | Which clock bytes to load |

## Verification
A corrupted pointer or section decode shows up on the very next read. The wrong byte, or a missing `rd_valid`, appears one cycle after the strobe. Each wrap point is therefore probed by a burst that reads back through the section boundary. A wrong write-enable state, or wrong staging contents, stays hidden until the next stop. It then appears either as an `rtc_set` pulse that should not happen, with a wrong mask, or as an alarm or control byte that changes in a later read. For this reason every commit path is followed by a read-back, or by sampling `rtc_set` in the cycle after the stop. Snapshot faults are exposed by changing `rtc_now` between the start and the read.

// File: rtl/clkreg_pkg.sv
// Shared constants, section type and address decode helpers for the
// sectioned clock register access controller.
// Assumes an 8-bit address and 8-bit data with 8-byte alarm and clock sections.
package clkreg_pkg;
    localparam int DW        = 8;
    localparam int AW        = 8;
    localparam int OFFW      = 3;
    localparam int SEC_BYTES = 1 << OFFW;
    localparam int CTL_BYTES = 4;
    localparam int CTLW      = $clog2(CTL_BYTES);
    localparam int NV_BYTES  = 2 * SEC_BYTES + CTL_BYTES;
    localparam int NVW       = $clog2(NV_BYTES);
    localparam int WEL_BIT   = 1;
    localparam int RWEL_BIT  = 2;

    localparam logic [AW-1:0] AL0_BASE = 8'h00;
    localparam logic [AW-1:0] AL1_BASE = 8'h08;
    localparam logic [AW-1:0] CTL_BASE = 8'h10;
    localparam logic [AW-1:0] RTC_BASE = 8'h30;
    localparam logic [AW-1:0] STS_ADDR = 8'h3F;

    typedef enum logic [2:0] {
        SEC_AL0, SEC_AL1, SEC_CTL, SEC_RTC, SEC_STS, SEC_NONE
    } sec_e;

    // Which section an address belongs to.
    function automatic sec_e sec_of(input logic [AW-1:0] a);
        sec_e s;
        s = SEC_NONE;
        if (a[AW-1:OFFW] == AL0_BASE[AW-1:OFFW])       s = SEC_AL0;
        else if (a[AW-1:OFFW] == AL1_BASE[AW-1:OFFW])  s = SEC_AL1;
        else if (a[AW-1:CTLW] == CTL_BASE[AW-1:CTLW])  s = SEC_CTL;
        else if (a[AW-1:OFFW] == RTC_BASE[AW-1:OFFW])  s = SEC_RTC;
        else if (a == STS_ADDR)                        s = SEC_STS;
        return s;
    endfunction

    // Number of bytes in a section.
    function automatic logic [OFFW:0] size_of(input sec_e s);
        logic [OFFW:0] n;
        case (s)
            SEC_AL0, SEC_AL1, SEC_RTC: n = (OFFW+1)'(SEC_BYTES);
            SEC_CTL:                   n = (OFFW+1)'(CTL_BYTES);
            SEC_STS:                   n = (OFFW+1)'(1);
            default:                   n = '0;
        endcase
        return n;
    endfunction

    // Byte offset of an address inside its section.
    function automatic logic [OFFW-1:0] offset_of(input logic [AW-1:0] a, input sec_e s);
        logic [OFFW-1:0] o;
        case (s)
            SEC_AL0, SEC_AL1, SEC_RTC: o = a[OFFW-1:0];
            SEC_CTL:                   o = OFFW'(a[CTLW-1:0]);
            default:                   o = '0;
        endcase
        return o;
    endfunction

    // Index into the internal alarm/control byte array.
    function automatic logic [NVW-1:0] nv_index(input sec_e s, input logic [OFFW-1:0] off);
        logic [NVW-1:0] idx;
        case (s)
            SEC_AL0: idx = NVW'(off);
            SEC_AL1: idx = NVW'(off) + NVW'(SEC_BYTES);
            SEC_CTL: idx = NVW'(off) + NVW'(2 * SEC_BYTES);
            default: idx = '0;
        endcase
        return idx;
    endfunction
endpackage

// File: rtl/clkreg_ptr.sv
// Address pointer kept as (section, offset). It loads from a full address and
// steps with a wrap inside the current section. Assumes load and step are
// not asserted together; when they are, load wins.
module clkreg_ptr
    import clkreg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [AW-1:0]   load_addr,
    input  logic            step,
    output sec_e            sec,
    output logic [OFFW-1:0] off
);
    logic [OFFW:0] sz;
    assign sz = size_of(sec);

    // Pointer register: load from address or advance with in-section wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec <= SEC_AL0;
            off <= '0;
        end else if (load) begin
            sec <= sec_of(load_addr);
            off <= offset_of(load_addr, sec_of(load_addr));
        end else if (step && sec != SEC_NONE) begin
            if ({1'b0, off} + (OFFW+1)'(1) == sz) off <= '0;
            else                                  off <= off + OFFW'(1);
        end
    end

    // R2
    ptr_in_section_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec != SEC_NONE) |-> ({1'b0, off} < sz));
endmodule

// File: rtl/clkreg_stage.sv
// Staging buffer for the bytes written in one operation. It records the data
// by section offset together with a written mask. Clear has priority over
// a write arriving in the same cycle.
module clkreg_stage #(
    parameter int DW = 8,
    parameter int NB = 8,
    localparam int OW = $clog2(NB)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   wr_en,
    input  logic [OW-1:0]          wr_off,
    input  logic [DW-1:0]          wr_data,
    output logic [NB-1:0][DW-1:0]  buf_data,
    output logic [NB-1:0]          buf_mask
);
    // Capture written bytes and track which offsets hold staged data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_data <= '0;
            buf_mask <= '0;
        end else if (clear) begin
            buf_mask <= '0;
        end else if (wr_en) begin
            buf_data[wr_off] <= wr_data;
            buf_mask[wr_off] <= 1'b1;
        end
    end

    // R10
    stage_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (buf_mask == '0));
endmodule

// File: rtl/clkreg_wen.sv
// Two-step write-enable latch held in the status register. Register
// write-enable can rise only when write-enable was already set before the
// write. Assumes sts_wr pulses once per committed status byte.
module clkreg_wen (
    input  logic clk,
    input  logic rst_n,
    input  logic sts_wr,
    input  logic sts_wel_in,
    input  logic sts_rwel_in,
    output logic wel,
    output logic rwel
);
    // Update both enable bits from a committed status byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (sts_wr) begin
            wel  <= sts_wel_in;
            rwel <= sts_wel_in & sts_rwel_in & wel;
        end
    end

    // R7
    rwel_needs_prior_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rwel) |-> $past(wel));

    // R7
    rwel_implies_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rwel |-> wel);
endmodule

// File: rtl/clkreg_access.sv
// Top of the sectioned clock register access controller. It tracks the
// operation, gates byte strobes by section rules, holds the alarm and
// control bytes, snapshots the clock at start and commits staged bytes at
// stop. Assumes the front end never raises start and stop in the same cycle.
module clkreg_access
    import clkreg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_start,
    input  logic                    bus_stop,
    input  logic                    addr_load,
    input  logic [7:0]              addr_in,
    input  logic                    wr_byte,
    input  logic [7:0]              wr_data,
    input  logic                    rd_byte,
    output logic [7:0]              rd_data,
    output logic                    rd_valid,
    input  logic [63:0]             rtc_now,
    output logic                    rtc_set,
    output logic [63:0]             rtc_set_data,
    output logic [7:0]              rtc_set_mask
);
    sec_e                              ptr_sec;
    logic [OFFW-1:0]                   ptr_off;
    logic [OFFW:0]                     ptr_size;
    logic [SEC_BYTES-1:0][DW-1:0]      stage_data;
    logic [SEC_BYTES-1:0]              stage_mask;
    logic [SEC_BYTES-1:0][DW-1:0]      snap_q;
    logic [NV_BYTES-1:0][DW-1:0]       nv_q;
    logic                              wel, rwel;
    logic                              op_active_q, op_dead_q, sts_used_q;
    logic                              byte_req, sts_extra, accept;
    logic                              commit_go, sts_commit, nv_commit, rtc_commit;
    logic [DW-1:0]                     rd_mux;

    assign ptr_size  = size_of(ptr_sec);
    assign byte_req  = wr_byte | rd_byte;
    assign sts_extra = (ptr_sec == SEC_STS) && sts_used_q;
    assign accept    = op_active_q && byte_req && !op_dead_q && !sts_extra
                       && (ptr_sec != SEC_NONE) && !bus_start && !addr_load;

    assign commit_go  = bus_stop && op_active_q && !bus_start && (stage_mask != '0);
    assign sts_commit = commit_go && (ptr_sec == SEC_STS);
    assign nv_commit  = commit_go && rwel &&
                        (ptr_sec == SEC_AL0 || ptr_sec == SEC_AL1 || ptr_sec == SEC_CTL);
    assign rtc_commit = commit_go && rwel && (ptr_sec == SEC_RTC);

    clkreg_ptr u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (addr_load),
        .load_addr (addr_in),
        .step      (accept),
        .sec       (ptr_sec),
        .off       (ptr_off)
    );

    clkreg_stage #(.DW(DW), .NB(SEC_BYTES)) u_stage (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (bus_start | addr_load),
        .wr_en    (accept & wr_byte),
        .wr_off   (ptr_off),
        .wr_data  (wr_data),
        .buf_data (stage_data),
        .buf_mask (stage_mask)
    );

    clkreg_wen u_wen (
        .clk         (clk),
        .rst_n       (rst_n),
        .sts_wr      (sts_commit),
        .sts_wel_in  (stage_data[0][WEL_BIT]),
        .sts_rwel_in (stage_data[0][RWEL_BIT]),
        .wel         (wel),
        .rwel        (rwel)
    );

    // Operation state: active window, termination and status byte use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_active_q <= 1'b0;
            op_dead_q   <= 1'b0;
            sts_used_q  <= 1'b0;
        end else if (bus_start) begin
            op_active_q <= 1'b1;
            op_dead_q   <= 1'b0;
            sts_used_q  <= 1'b0;
        end else if (bus_stop) begin
            op_active_q <= 1'b0;
        end else begin
            if (op_active_q && byte_req && sts_extra) op_dead_q <= 1'b1;
            if (addr_load)                             sts_used_q <= 1'b0;
            else if (accept && ptr_sec == SEC_STS)     sts_used_q <= 1'b1;
        end
    end

    // Clock snapshot taken at every start.
    always_ff @(posedge clk) begin
        if (!rst_n)         snap_q <= '0;
        else if (bus_start) snap_q <= rtc_now;
    end

    // Alarm and control storage, written only by a permitted commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q <= '0;
        end else if (nv_commit) begin
            for (int i = 0; i < SEC_BYTES; i++) begin
                if (stage_mask[i] && ((OFFW+1)'(i) < ptr_size))
                    nv_q[nv_index(ptr_sec, OFFW'(i))] <= stage_data[i];
            end
        end
    end

    // Read source selection for the current pointer.
    always_comb begin
        case (ptr_sec)
            SEC_AL0, SEC_AL1, SEC_CTL: rd_mux = nv_q[nv_index(ptr_sec, ptr_off)];
            SEC_RTC:                   rd_mux = snap_q[ptr_off];
            SEC_STS: begin
                rd_mux           = '0;
                rd_mux[WEL_BIT]  = wel;
                rd_mux[RWEL_BIT] = rwel;
            end
            default:                   rd_mux = '0;
        endcase
    end

    // Registered read data and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= accept && rd_byte;
            if (accept && rd_byte) rd_data <= rd_mux;
        end
    end

    // Clock load pulse with data and byte mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rtc_set      <= 1'b0;
            rtc_set_data <= '0;
            rtc_set_mask <= '0;
        end else begin
            rtc_set <= rtc_commit;
            if (rtc_commit) begin
                rtc_set_data <= stage_data;
                rtc_set_mask <= stage_mask;
            end else begin
                rtc_set_mask <= '0;
            end
        end
    end

    // R12
    rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_byte));

    // R11
    rtc_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_set |-> ($past(bus_stop) && $past(rwel)));

    // R11
    rtc_set_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_set |=> !rtc_set);

    // R5
    nv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_stop) |-> $stable(nv_q));
endmodule

// File: tb/clkreg_access_tb.sv
`timescale 1ns/1ps
module clkreg_access_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0, bus_stop = 1'b0, addr_load = 1'b0;
    logic [7:0]  addr_in = '0;
    logic        wr_byte = 1'b0, rd_byte = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [63:0] rtc_now = '0;
    logic        rtc_set;
    logic [63:0] rtc_set_data;
    logic [7:0]  rtc_set_mask;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [63:0] P1 = 64'h8877665544332211;
    localparam logic [63:0] P2 = 64'h0F1E2D3C4B5A6978;

    always #2.5 clk = ~clk;

    clkreg_access u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .addr_load(addr_load), .addr_in(addr_in), .wr_byte(wr_byte), .wr_data(wr_data),
        .rd_byte(rd_byte), .rd_data(rd_data), .rd_valid(rd_valid), .rtc_now(rtc_now),
        .rtc_set(rtc_set), .rtc_set_data(rtc_set_data), .rtc_set_mask(rtc_set_mask)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        bus_start = 1'b1; @(negedge clk); bus_start = 1'b0;
    endtask

    task automatic do_stop(output logic set_seen);
        bus_stop = 1'b1; @(negedge clk); bus_stop = 1'b0;
        set_seen = rtc_set;
    endtask

    task automatic do_addr(input logic [7:0] a);
        addr_load = 1'b1; addr_in = a; @(negedge clk); addr_load = 1'b0;
    endtask

    task automatic do_wr(input logic [7:0] d);
        wr_byte = 1'b1; wr_data = d; @(negedge clk); wr_byte = 1'b0;
    endtask

    task automatic do_rd(output logic [7:0] d, output logic v);
        rd_byte = 1'b1; @(negedge clk); rd_byte = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic rd_exp(input string tag, input logic [7:0] exp);
        logic [7:0] d; logic v;
        do_rd(d, v);
        chk({tag, " valid"}, 64'(v), 64'(1));
        chk(tag, 64'(d), 64'(exp));
    endtask

    task automatic rd_none(input string tag);
        logic [7:0] d; logic v;
        do_rd(d, v);
        chk(tag, 64'(v), 64'(0));
    endtask

    task automatic read_at(input string tag, input logic [7:0] a, input logic [7:0] exp);
        logic s;
        do_start(); do_addr(a); rd_exp(tag, exp); do_stop(s);
    endtask

    task automatic sts_write(input logic [7:0] b);
        logic s;
        do_start(); do_addr(8'h3F); do_wr(b); do_stop(s);
    endtask

    task automatic t_reset();
        chk("R1 rd_valid low", 64'(rd_valid), 64'(0));
        chk("R1 rtc_set low", 64'(rtc_set), 64'(0));
        begin
            logic s;
            do_start(); rd_exp("R1 pointer at alarm byte 0", 8'h00); do_stop(s);
        end
        read_at("R1 status zero", 8'h3F, 8'h00);
        read_at("R1 control zero", 8'h12, 8'h00);
    endtask

    task automatic t_wen();
        sts_write(8'h06);
        read_at("R7 rwel blocked without prior wel", 8'h3F, 8'h02);
        sts_write(8'h06);
        read_at("R7 rwel after two steps", 8'h3F, 8'h06);
        sts_write(8'hFF);
        read_at("R6 other bits read zero", 8'h3F, 8'h06);
        sts_write(8'h04);
        read_at("R7 clearing wel clears both", 8'h3F, 8'h00);
    endtask

    task automatic t_locked_write();
        logic s;
        sts_write(8'h02);
        do_start(); do_addr(8'h10); do_wr(8'hAA); do_stop(s);
        read_at("R5 no commit without rwel", 8'h10, 8'h00);
        sts_write(8'h06);
    endtask

    task automatic t_no_byte_stop();
        logic s;
        do_start(); do_addr(8'h08); do_wr(8'h5A);
        do_start(); do_stop(s);
        chk("R10 no clock pulse", 64'(s), 64'(0));
        read_at("R10 restart discards staging", 8'h08, 8'h00);
        do_start(); do_addr(8'h3F); do_stop(s);
        read_at("R10 status kept after empty op", 8'h3F, 8'h06);
    endtask

    task automatic t_wrap_write();
        logic s;
        do_start(); do_addr(8'h12);
        do_wr(8'h11); do_wr(8'h22); do_wr(8'h33);
        do_stop(s);
        do_start(); do_addr(8'h10);
        rd_exp("R2 write wrapped to 0x10", 8'h33);
        rd_exp("R2 0x11 untouched", 8'h00);
        rd_exp("R5 committed 0x12", 8'h11);
        rd_exp("R5 committed 0x13", 8'h22);
        rd_exp("R2 read wraps 0x13 to 0x10", 8'h33);
        do_stop(s);
    endtask

    task automatic t_alarm_b();
        logic s;
        do_start(); do_addr(8'h0F); do_wr(8'hA1); do_wr(8'hB2); do_stop(s);
        read_at("R3 alarm B wrap to 0x08", 8'h08, 8'hB2);
        read_at("R3 alarm B 0x0F", 8'h0F, 8'hA1);
        read_at("R3 alarm A separate", 8'h07, 8'h00);
    endtask

    task automatic t_invalid();
        logic s;
        do_start(); do_addr(8'h20);
        rd_none("R3 unmapped read ignored");
        do_wr(8'h77);
        do_stop(s);
        chk("R3 unmapped write no pulse", 64'(s), 64'(0));
        do_start(); do_addr(8'h14); rd_none("R3 0x14 ignored"); do_stop(s);
        read_at("R3 control intact", 8'h10, 8'h33);
    endtask

    task automatic t_snapshot();
        logic s;
        rtc_now = P1;
        do_start();
        rtc_now = P2;
        do_addr(8'h30);
        for (int i = 0; i < 8; i++) rd_exp("R8 snapshot byte", P1[8*i +: 8]);
        rd_exp("R2 clock wraps to 0x30", P1[7:0]);
        do_stop(s);
        read_at("R8 new start takes new snapshot", 8'h30, P2[7:0]);
    endtask

    task automatic t_pointer();
        logic s;
        do_start(); do_addr(8'h35); rd_exp("R9 seed read", P2[47:40]); do_stop(s);
        @(negedge clk);
        chk("R12 rd_valid one cycle", 64'(rd_valid), 64'(0));
        do_start(); rd_exp("R9 continues at +1", P2[55:48]); do_stop(s);
        do_start(); rd_exp("R9 continues at 0x37", P2[63:56]); do_stop(s);
        do_start(); rd_exp("R9 pointer wrapped in section", P2[7:0]); do_stop(s);
    endtask

    task automatic t_rtc_commit();
        logic s;
        do_start(); do_addr(8'h32); do_wr(8'h45); do_wr(8'h19);
        do_stop(s);
        chk("R11 pulse after stop", 64'(s), 64'(1));
        chk("R11 mask", 64'(rtc_set_mask), 64'(8'h0C));
        chk("R11 byte 2", 64'(rtc_set_data[23:16]), 64'(8'h45));
        chk("R11 byte 3", 64'(rtc_set_data[31:24]), 64'(8'h19));
        @(negedge clk);
        chk("R11 single cycle", 64'(rtc_set), 64'(0));
    endtask

    task automatic t_status_single();
        logic s;
        do_start(); do_addr(8'h3F);
        rd_exp("R4 first status byte", 8'h06);
        rd_none("R4 second byte ends op");
        rd_none("R4 op stays ended");
        do_stop(s);
        do_start(); do_addr(8'h3F); do_wr(8'h02); do_wr(8'h00); do_stop(s);
        read_at("R4 extra write ignored", 8'h3F, 8'h02);
    endtask

    task automatic t_rtc_locked();
        logic s;
        do_start(); do_addr(8'h30); do_wr(8'h99); do_stop(s);
        chk("R5 clock write blocked", 64'(s), 64'(0));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_wen();
        t_locked_write();
        t_no_byte_stop();
        t_wrap_write();
        t_alarm_b();
        t_invalid();
        t_snapshot();
        t_pointer();
        t_rtc_commit();
        t_status_single();
        t_rtc_locked();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule